// File: doc/BRIEF.md
# Timer Standby Clock Gating Controller

This block puts a device into a low-power timer standby state and brings it back out. Software arms it through a small register interface. A key-protected standby control register selects the standby flavour and how the external pins behave. A second register holds a real-time-mode enable, which must be cleared before standby can be entered. Once the block is armed, the processor requests entry by asserting its deep-sleep enable together with a wait-for-interrupt or wait-for-event indication.

In standby, the block gates off the base clock to the processor, system bus, peripheral bus and debug domains, using glitch-free latch-based gates. The enables for the oscillators, PLL, watchdog, watch counter, real-time clock, clock failure detector and low-voltage detector stay asserted. The external pins are either held at their last state or tristated. The block also records which clock source was active at entry, so the standby variant is known.

A pending interrupt wakes the block. It first restores the clocks and releases the pins, and only after that pulses a wake indication to the processor. A synchronous reset also ends standby and returns both registers to their defaults.

Top module: `stby_gate_ctrl`

## Requirements
- R1: A write to the standby control register (wr_sel=0) changes it only when wr_data[31:16] equals 0x1ACC and the block is running (not in standby or wake). Any other key, and any write made while not running, leaves both registers unchanged.
- R2: Reading with rd_sel=0 returns mode in bits [1:0], the deep-standby select in bit 2 and the pin-tristate bit in bit 4, with zeros elsewhere (the key field reads as zero). Reading with rd_sel=1 returns the real-time-mode enable in bit 0. Writes with wr_sel=1 load that bit from wr_data[0] without a key.
- R3: Reset clears mode, deep select and pin-tristate to 0, sets the real-time-mode enable to 1, and returns the block to the running state with all gated clocks enabled.
- R4: Standby is entered on the clock edge where deep-sleep enable is 1, wfi or wfe is 1, mode is 0b00, deep select is 0 and the real-time-mode enable is 0 (all register values as held before that edge). If any of these is missing, the block stays running. stby_active is 1 exactly while the block is in standby.
- R5: From the first clock edge after entry, until the edge after the wake edge, the four gated clocks (index 0 CPU, 1 system bus, 2 peripheral bus, 3 debug) produce no rising edge. Afterwards they follow the source clock again.
- R6: Every always-on enable output stays 1 at all times, including during standby.
- R7: In standby, pin-tristate 0 asserts pin_hold and pin-tristate 1 asserts pin_hiz. Outside standby, both are 0, and they are never 1 together.
- R8: An interrupt sampled in standby ends standby on that edge: stby_active, pin_hold and pin_hiz drop and the clocks are re-enabled. On the following edge, cpu_wake goes high for exactly one cycle.
- R9: A reset asserted during standby ends it and restores the register defaults of R3.
- R10: At entry, stby_kind captures the clock source from clk_mode: 000 high-speed RC gives 0, 001 main oscillator gives 1, 010 PLL gives 2, 100 low-speed RC gives 3, 101 sub oscillator gives 4, and any other code gives 0. It holds that value until the next entry or reset (reset value 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock source |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 standby control, 1 real-time-mode register |
| wr_data | input | 32 | Write data, key in [31:16] for the standby control register |
| rd_sel | input | 1 | Read target: 0 standby control, 1 real-time-mode register |
| rd_data | output | 32 | Read data |
| cpu_deepsleep | input | 1 | Processor deep-sleep enable |
| cpu_wfi | input | 1 | Processor wait-for-interrupt |
| cpu_wfe | input | 1 | Processor wait-for-event |
| irq_pending | input | 1 | Any enabled interrupt pending |
| clk_mode | input | 3 | Active clock source status code |
| gated_clk | output | 4 | Gated clocks: CPU, system bus, peripheral bus, debug |
| aon_en | output | 7 | Enables for always-on oscillators, PLL and timers |
| pin_hold | output | 1 | Hold external pins at last state |
| pin_hiz | output | 1 | Tristate external pins |
| stby_active | output | 1 | Block is in timer standby |
| stby_kind | output | 3 | Captured standby variant code |
| cpu_wake | output | 1 | One-cycle wake pulse to the processor |

## Verification
The entry condition is tried one missing input at a time: no deep-sleep enable, a nonzero mode, deep select set, and the real-time-mode enable still set. Each of these must leave the block running, while the full set, with either wfi or wfe, enters standby. That shows each term is really required. Writes with a wrong key and writes issued during standby tell the key check apart from the running-state guard. Wake-up is tried both by interrupt, which checks the gated-clock edge counts, pin release and wake pulse timing, and by reset, which must also restore the register defaults. Several clock-mode codes, including one that is not recognised, separate the variant decode cases.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned KEY_LSB    = 16;
    localparam int unsigned KEY_W      = 16;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h1ACC;

    localparam int unsigned MODE_LSB   = 0;
    localparam int unsigned DEEP_BIT   = 2;
    localparam int unsigned TRI_BIT    = 4;
    localparam int unsigned RTM_BIT    = 0;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STBY = 2'd1,
        ST_WAKE = 2'd2
    } stby_state_e;

    typedef enum logic [2:0] {
        K_HSRC = 3'd0,
        K_MAIN = 3'd1,
        K_PLL  = 3'd2,
        K_LSRC = 3'd3,
        K_SUB  = 3'd4
    } stby_kind_e;

    typedef struct packed {
        logic       pin_tri;
        logic       deep_sel;
        logic [1:0] mode;
    } stby_cfg_t;

    localparam stby_cfg_t CFG_RESET = '{pin_tri: 1'b0, deep_sel: 1'b0, mode: 2'b00};

    function automatic stby_kind_e decode_kind(input logic [2:0] code);
        stby_kind_e k;
        case (code)
            3'b001:  k = K_MAIN;
            3'b010:  k = K_PLL;
            3'b100:  k = K_LSRC;
            3'b101:  k = K_SUB;
            default: k = K_HSRC;
        endcase
        return k;
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input stby_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[MODE_LSB +: 2] = c.mode;
        w[DEEP_BIT]      = c.deep_sel;
        w[TRI_BIT]       = c.pin_tri;
        return w;
    endfunction

    function automatic stby_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        stby_cfg_t c;
        c.mode     = w[MODE_LSB +: 2];
        c.deep_sel = w[DEEP_BIT];
        c.pin_tri  = w[TRI_BIT];
        return c;
    endfunction

endpackage

// File: rtl/stby_regs.sv
module stby_regs
    import stby_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wr_allow,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    output stby_cfg_t        cfg,
    output logic             rtm_en
);

    stby_cfg_t cfg_q;
    logic      rtm_q;
    logic      key_ok;
    logic      cfg_wr;
    logic      rtm_wr;

    assign key_ok = (wr_data[KEY_LSB +: KEY_W] == UNLOCK_KEY);
    assign cfg_wr = wr_en && wr_allow && !wr_sel && key_ok;
    assign rtm_wr = wr_en && wr_allow && wr_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
            rtm_q <= 1'b1;
        end else begin
            if (cfg_wr) begin
                cfg_q <= unpack_cfg(wr_data);
            end
            if (rtm_wr) begin
                rtm_q <= wr_data[RTM_BIT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[RTM_BIT] = rtm_q;
        end else begin
            rd_data = pack_cfg(cfg_q);
        end
    end

    assign cfg    = cfg_q;
    assign rtm_en = rtm_q;

    // R1: a write carrying a wrong key leaves the control register alone
    assert_badkey_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && !key_ok) |=> $stable(cfg_q));

    // R1: nothing changes while writes are blocked
    assert_locked_in_stby_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_allow) |=> ($stable(cfg_q) && $stable(rtm_q)));

    // R3: the cycle after reset holds the defaults
    assert_reset_defaults_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == CFG_RESET && rtm_q));

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stby_cfg_t  cfg,
    input  logic       rtm_en,
    input  logic       cpu_deepsleep,
    input  logic       cpu_wfi,
    input  logic       cpu_wfe,
    input  logic       irq_pending,
    input  logic [2:0] clk_mode,
    output logic       clk_on,
    output logic       running,
    output logic       pin_hold,
    output logic       pin_hiz,
    output logic       stby_active,
    output logic       cpu_wake,
    output logic [2:0] stby_kind
);

    stby_state_e state_q;
    stby_state_e state_d;
    stby_kind_e  kind_q;
    logic        wake_q;
    logic        entry_ok;
    logic        timer_sel;

    assign timer_sel = (cfg.mode == 2'b00) && !cfg.deep_sel;
    assign entry_ok  = cpu_deepsleep && (cpu_wfi || cpu_wfe) && timer_sel && !rtm_en;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_RUN:  if (entry_ok)    state_d = ST_STBY;
            ST_STBY: if (irq_pending) state_d = ST_WAKE;
            ST_WAKE:                  state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            kind_q  <= K_HSRC;
            wake_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wake_q  <= (state_q == ST_WAKE);
            if (state_q == ST_RUN && entry_ok) begin
                kind_q <= decode_kind(clk_mode);
            end
        end
    end

    assign stby_active = (state_q == ST_STBY);
    assign running     = (state_q == ST_RUN);
    assign clk_on      = !stby_active;
    assign pin_hold    = stby_active && !cfg.pin_tri;
    assign pin_hiz     = stby_active && cfg.pin_tri;
    assign cpu_wake    = wake_q;
    assign stby_kind   = kind_q;

    // R4: without the full entry condition the block keeps running
    assert_entry_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !entry_ok) |=> (state_q == ST_RUN));

    // R7: hold and tristate are mutually exclusive
    assert_pins_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(pin_hold && pin_hiz));

    // R8: an interrupt in standby leads out of it on the next edge
    assert_irq_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STBY && irq_pending) |=> !stby_active);

    // R8: by the time the wake pulse is seen, clocks and pins are released
    assert_wake_released_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_wake |-> (clk_on && !pin_hold && !pin_hiz && !stby_active));

    // R8: the wake pulse lasts one cycle
    assert_wake_single_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_wake |=> !cpu_wake);

endmodule

// File: rtl/stby_clk_gate.sv
module stby_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_lat;

    // enable is sampled only while the clock is low, so the gated output
    // can neither shorten nor split a high phase
    always_latch begin
        if (!clk) begin
            en_lat <= en;
        end
    end

    assign gclk = clk & en_lat;

endmodule

// File: rtl/stby_gate_ctrl.sv
module stby_gate_ctrl
    import stby_pkg::*;
#(
    parameter int unsigned NUM_GATED = 4,
    parameter int unsigned NUM_AON   = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [31:0]          wr_data,
    input  logic                 rd_sel,
    output logic [31:0]          rd_data,
    input  logic                 cpu_deepsleep,
    input  logic                 cpu_wfi,
    input  logic                 cpu_wfe,
    input  logic                 irq_pending,
    input  logic [2:0]           clk_mode,
    output logic [NUM_GATED-1:0] gated_clk,
    output logic [NUM_AON-1:0]   aon_en,
    output logic                 pin_hold,
    output logic                 pin_hiz,
    output logic                 stby_active,
    output logic [2:0]           stby_kind,
    output logic                 cpu_wake
);

    stby_cfg_t cfg;
    logic      rtm_en;
    logic      clk_on;
    logic      running;

    stby_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .wr_allow (running),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .cfg      (cfg),
        .rtm_en   (rtm_en)
    );

    stby_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .cfg           (cfg),
        .rtm_en        (rtm_en),
        .cpu_deepsleep (cpu_deepsleep),
        .cpu_wfi       (cpu_wfi),
        .cpu_wfe       (cpu_wfe),
        .irq_pending   (irq_pending),
        .clk_mode      (clk_mode),
        .clk_on        (clk_on),
        .running       (running),
        .pin_hold      (pin_hold),
        .pin_hiz       (pin_hiz),
        .stby_active   (stby_active),
        .cpu_wake      (cpu_wake),
        .stby_kind     (stby_kind)
    );

    for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
        stby_clk_gate u_gate (
            .clk  (clk),
            .en   (clk_on),
            .gclk (gated_clk[g])
        );
    end

    // always-on domains are never switched by this block
    assign aon_en = {NUM_AON{1'b1}};

    // R3: the cycle after reset the block is running with clocks enabled
    assert_reset_running_R3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!stby_active && clk_on && !cpu_wake));

endmodule

// File: tb/stby_gate_ctrl_tb_top.sv
module stby_gate_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_sel, rd_sel;
    logic [31:0] wr_data, rd_data;
    logic        cpu_deepsleep, cpu_wfi, cpu_wfe, irq_pending;
    logic [2:0]  clk_mode;
    logic [3:0]  gated_clk;
    logic [6:0]  aon_en;
    logic        pin_hold, pin_hiz, stby_active, cpu_wake;
    logic [2:0]  stby_kind;

    always #10 clk = ~clk;

    stby_gate_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .cpu_deepsleep(cpu_deepsleep),
        .cpu_wfi(cpu_wfi), .cpu_wfe(cpu_wfe), .irq_pending(irq_pending),
        .clk_mode(clk_mode), .gated_clk(gated_clk), .aon_en(aon_en),
        .pin_hold(pin_hold), .pin_hiz(pin_hiz), .stby_active(stby_active),
        .stby_kind(stby_kind), .cpu_wake(cpu_wake)
    );

    int checks = 0;
    int errors = 0;
    int edges [4];
    int snap  [4];
    bit done = 0;

    always @(posedge gated_clk[0]) edges[0]++;
    always @(posedge gated_clk[1]) edges[1]++;
    always @(posedge gated_clk[2]) edges[2]++;
    always @(posedge gated_clk[3]) edges[3]++;

    // behavioural reference state
    int          m_st;     // 0 running, 1 standby, 2 waking
    logic [1:0]  m_mode;
    logic        m_deep, m_tri, m_rtm, m_wake;
    int          m_kind;

    function automatic int kind_of(logic [2:0] c);
        case (c)
            3'b001: return 1;
            3'b010: return 2;
            3'b100: return 3;
            3'b101: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit go;
        bit nw;
        if (rst) begin
            m_mode = 0; m_deep = 0; m_tri = 0; m_rtm = 1;
            m_st = 0; m_wake = 0; m_kind = 0;
        end else begin
            nw = (m_st == 2);
            go = cpu_deepsleep && (cpu_wfi || cpu_wfe) && m_mode == 0 && !m_deep && !m_rtm;
            if (m_st == 0) begin
                if (go) m_kind = kind_of(clk_mode);
                if (wr_en && !wr_sel && wr_data[31:16] == 16'h1ACC) begin
                    m_mode = wr_data[1:0]; m_deep = wr_data[2]; m_tri = wr_data[4];
                end
                if (wr_en && wr_sel) m_rtm = wr_data[0];
                if (go) m_st = 1;
            end else if (m_st == 1) begin
                if (irq_pending) m_st = 2;
            end else begin
                m_st = 0;
            end
            m_wake = nw;
        end
    endtask

    task automatic compare_all();
        logic [31:0] exp_rd;
        exp_rd = rd_sel ? {31'b0, m_rtm} : {27'b0, m_tri, 1'b0, m_deep, m_mode};
        chk("R4 stby_active", {31'b0, stby_active}, {31'b0, m_st == 1});
        chk("R7 pin_hold", {31'b0, pin_hold}, {31'b0, m_st == 1 && !m_tri});
        chk("R7 pin_hiz", {31'b0, pin_hiz}, {31'b0, m_st == 1 && m_tri});
        chk("R8 cpu_wake", {31'b0, cpu_wake}, {31'b0, m_wake});
        chk("R10 stby_kind", {29'b0, stby_kind}, m_kind);
        chk("R2 rd_data", rd_data, exp_rd);
        chk("R6 aon_en", {25'b0, aon_en}, 32'h7F);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        rd_sel = ~rd_sel;
    endtask

    task automatic idle();
        wr_en = 0; cpu_deepsleep = 0; cpu_wfi = 0; cpu_wfe = 0; irq_pending = 0;
    endtask

    task automatic write(bit sel, logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic sleep_req(bit use_wfe);
        cpu_deepsleep = 1; cpu_wfi = !use_wfe; cpu_wfe = use_wfe;
        step();
        cpu_deepsleep = 0; cpu_wfi = 0; cpu_wfe = 0;
    endtask

    task automatic take_snap();
        for (int i = 0; i < 4; i++) snap[i] = edges[i];
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; rd_sel = 0; wr_sel = 0; wr_data = 0; clk_mode = 3'b000;
        for (int i = 0; i < 4; i++) edges[i] = 0;
        idle();
        step(); step();
        rst = 0;
        step();
        // R3: defaults after reset
        rd_sel = 0; step();
        chk("R3 cfg default", rd_data, 32'h0);
        rd_sel = 1; step();
        chk("R3 rtm default", rd_data, 32'h1);

        // R1: wrong key ignored
        write(0, {16'h1ACD, 16'h0013});
        rd_sel = 0; step();
        chk("R1 bad key ignored", rd_data, 32'h0);
        write(0, {16'h1ACC, 16'h0001});
        rd_sel = 0; step();
        chk("R2 mode readback key zero", rd_data, 32'h1);

        // R4: rtm still set, mode zero -> no entry
        write(0, {16'h1ACC, 16'h0000});
        sleep_req(0);
        chk("R4 rtm blocks entry", {31'b0, stby_active}, 0);
        write(1, 32'h0);
        // R4: deep-sleep enable missing
        cpu_wfi = 1; step(); cpu_wfi = 0;
        chk("R4 no deepsleep no entry", {31'b0, stby_active}, 0);
        // R4: nonzero mode
        write(0, {16'h1ACC, 16'h0002});
        sleep_req(0);
        chk("R4 mode blocks entry", {31'b0, stby_active}, 0);
        // R4: deep select set
        write(0, {16'h1ACC, 16'h0004});
        sleep_req(1);
        chk("R4 deep blocks entry", {31'b0, stby_active}, 0);
        // R4: deep-sleep without wfi/wfe
        write(0, {16'h1ACC, 16'h0000});
        cpu_deepsleep = 1; step(); cpu_deepsleep = 0;
        chk("R4 no wait no entry", {31'b0, stby_active}, 0);

        // Entry with hold pins, PLL source
        clk_mode = 3'b010;
        sleep_req(0);
        chk("R4 entered", {31'b0, stby_active}, 1);
        chk("R7 hold asserted", {30'b0, pin_hold, pin_hiz}, 32'h2);
        chk("R10 PLL kind", {29'b0, stby_kind}, 2);
        take_snap();
        clk_mode = 3'b101;
        for (int i = 0; i < 4; i++) step();
        // R1: writes while in standby ignored
        write(0, {16'h1ACC, 16'h0010});
        write(1, 32'h1);
        for (int i = 0; i < 4; i++)
            chk("R5 no gated edges in standby", edges[i], snap[i]);
        chk("R6 aon stays on", {25'b0, aon_en}, 32'h7F);
        // R8: wake by interrupt
        irq_pending = 1; step(); irq_pending = 0;
        chk("R8 left standby", {30'b0, stby_active, cpu_wake}, 0);
        chk("R8 pins released", {30'b0, pin_hold, pin_hiz}, 0);
        for (int i = 0; i < 4; i++)
            chk("R5 still gated at wake edge", edges[i], snap[i]);
        take_snap();
        step();
        chk("R8 wake pulse", {31'b0, cpu_wake}, 1);
        for (int i = 0; i < 4; i++)
            chk("R5 clock resumed", edges[i] - snap[i], 1);
        step();
        chk("R8 wake pulse ends", {31'b0, cpu_wake}, 0);
        rd_sel = 0; step();
        chk("R1 standby write dropped", rd_data, 32'h0);
        rd_sel = 1; step();
        chk("R1 standby rtm write dropped", rd_data, 32'h0);

        // Tristate pins, wfe, sub source; then reset out of standby
        write(0, {16'h1ACC, 16'h0010});
        clk_mode = 3'b101;
        sleep_req(1);
        chk("R7 hiz asserted", {30'b0, pin_hold, pin_hiz}, 32'h1);
        chk("R10 sub kind", {29'b0, stby_kind}, 4);
        step();
        rst = 1; step(); rst = 0;
        chk("R9 reset ends standby", {31'b0, stby_active}, 0);
        rd_sel = 0; step();
        chk("R9 cfg cleared", rd_data, 32'h0);
        rd_sel = 1; step();
        chk("R9 rtm restored", rd_data, 32'h1);
        take_snap(); step();
        chk("R3 clocks on after reset", edges[0] - snap[0], 1);

        // unrecognised source code, low-speed RC code
        write(1, 32'h0);
        clk_mode = 3'b111;
        sleep_req(0);
        chk("R10 unknown code kind", {29'b0, stby_kind}, 0);
        irq_pending = 1; step(); irq_pending = 0;
        step(); step();
        clk_mode = 3'b100;
        sleep_req(0);
        chk("R10 low-speed RC kind", {29'b0, stby_kind}, 3);
        irq_pending = 1; step(); irq_pending = 0;
        step(); step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule